// File: doc/BRIEF.md
# Brightness Gamma Table Sequencer

This block turns a brightness level request into the command traffic that a display panel needs to change its gamma curve. When a start strobe is taken, it streams one fixed-length gamma packet to a downstream serial command writer. The packet opens with the gamma-control command and a hold byte, and the per-level gamma values follow. A short commit packet then tells the panel to apply the table it has just received. Each byte is handed over with a valid/ready handshake. Flags mark the opening byte and the closing byte of each packet.

The gamma values come from an internal ROM that is built from a parameter vector. By default that vector is filled with a computed pattern, and an integration can supply its own table instead. The block holds a sticky copy of any error that the command writer reports. While that error is held, requests complete at once with an error indication and send nothing. A single-cycle done pulse ends every accepted request, and an error flag qualifies it.

Top module: `gamma_seq`

## Requirements
- R1: Out of reset the block is idle: busy, valid and done are low, and the reported current level is 10, the maximum of the levels 0 to 10.
- R2: For an in-range level L, a level packet of exactly 23 bytes goes out. Byte 0 is 0xFA and byte 1 is 0x00. In the default configuration, byte 2+k (k = 0..20) is (L*11 + k*37 + 24) mod 256.
- R3: Once the level packet has been taken, and only when no writer error is held, a commit packet of two bytes follows, 0xFA then 0x01.
- R4: The first flag is high only on byte 0 of each packet, and the last flag is high only on the final byte of each packet (byte 22 of a level packet, byte 1 of a commit packet).
- R5: A byte moves on only when valid and ready are both high. While valid is high and ready is low, the data and both flags hold steady.
- R6: In the cycle after the commit packet's final handshake, done pulses for exactly one cycle with error low. The current level takes the value L when a request is accepted in range with no error held.
- R7: A request for a level above 10 sends no bytes and completes with done and error high. The current level stays unchanged.
- R8: When the writer reports an error during a level packet, that packet still completes, no commit packet follows, and done comes with error high. Later requests send nothing and complete with error high until the clear input is pulsed, after which requests behave normally again.
- R9: Busy is high from the cycle after a request is accepted through the done cycle. A start strobe that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken when idle |
| level_i | input | 4 | Requested brightness level |
| wr_ready_i | input | 1 | Command writer can take a byte |
| wr_err_i | input | 1 | Command writer reports a failure |
| err_clr_i | input | 1 | Clears the held writer error |
| wr_valid_o | output | 1 | Byte on wr_data_o is valid |
| wr_data_o | output | 8 | Command byte |
| wr_first_o | output | 1 | Byte is the first of a packet |
| wr_last_o | output | 1 | Byte is the last of a packet |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completion carries an error |
| cur_level_o | output | 4 | Level of the last accepted request |

## Verification
The hold and ordering properties assume that the command writer never takes back a byte it has not yet accepted, and that reset is held long enough to clear the sequencer state. The stimulus keeps ready a plain level that changes only just after a clock edge. The stimulus keeps start and the error inputs as single-cycle pulses driven away from the edge, so every stall, restart and error injection lands at a well-defined point in the packet stream. Error injection is timed to fall inside a level packet, which gives the completion of the packet and the dropped commit a deterministic outcome.

// File: rtl/gamma_seq.sv
module gamma_seq #(
  parameter int NUM_LEVELS = 11,
  parameter int PKT_BYTES  = 23,
  parameter int LVL_W      = 4,
  parameter bit USE_TABLE  = 1'b0,
  parameter logic [NUM_LEVELS*(PKT_BYTES-2)*8-1:0] GAMMA_TABLE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             wr_ready_i,
  input  logic             wr_err_i,
  input  logic             err_clr_i,
  output logic             wr_valid_o,
  output logic [7:0]       wr_data_o,
  output logic             wr_first_o,
  output logic             wr_last_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [LVL_W-1:0] cur_level_o
);

  localparam int PAY   = PKT_BYTES - 2;
  localparam int ROM_N = NUM_LEVELS * PAY;
  localparam int IDX_W = $clog2(PKT_BYTES);
  localparam int SEL_W = $clog2(ROM_N);
  localparam logic [7:0] CMD_GAMMA = 8'hFA;
  localparam logic [7:0] ARG_HOLD  = 8'h00;
  localparam logic [7:0] ARG_APPLY = 8'h01;
  localparam logic [LVL_W-1:0] MAX_LVL = LVL_W'(NUM_LEVELS - 1);

  function automatic logic [ROM_N*8-1:0] make_rom();
    logic [ROM_N*8-1:0] r;
    r = '0;
    for (int l = 0; l < NUM_LEVELS; l++)
      for (int k = 0; k < PAY; k++)
        r[(l*PAY+k)*8 +: 8] = 8'((l*11 + k*37 + 24) % 256);
    return r;
  endfunction

  localparam logic [ROM_N*8-1:0] ROM = USE_TABLE ? GAMMA_TABLE : make_rom();

  typedef enum logic [1:0] {S_IDLE, S_LVL, S_CMT, S_FIN} st_t;

  st_t              st;
  logic [IDX_W-1:0] idx;
  logic [LVL_W-1:0] lvl_q;
  logic             err_q;
  logic             rng_q;
  logic [SEL_W-1:0] sel;
  logic [7:0]       rom_byte;

  wire hs       = wr_valid_o & wr_ready_i;
  wire last_lvl = (idx == IDX_W'(PKT_BYTES - 1));
  wire last_cmt = (idx == IDX_W'(1));
  wire in_range = (level_i <= MAX_LVL);

  always_comb begin
    sel      = SEL_W'(lvl_q) * SEL_W'(PAY) + SEL_W'(idx) - SEL_W'(2);
    rom_byte = ROM[int'(sel)*8 +: 8];
  end

  always_comb begin
    case (st)
      S_LVL:   wr_data_o = (idx == '0) ? CMD_GAMMA :
                           (idx == IDX_W'(1)) ? ARG_HOLD : rom_byte;
      S_CMT:   wr_data_o = (idx == '0) ? CMD_GAMMA : ARG_APPLY;
      default: wr_data_o = 8'h00;
    endcase
  end

  assign wr_valid_o  = (st == S_LVL) || (st == S_CMT);
  assign wr_first_o  = wr_valid_o && (idx == '0);
  assign wr_last_o   = ((st == S_LVL) && last_lvl) || ((st == S_CMT) && last_cmt);
  assign busy_o      = (st != S_IDLE);
  assign done_o      = (st == S_FIN);
  assign err_o       = done_o && (err_q || rng_q);
  assign cur_level_o = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (wr_err_i) begin
      err_q <= 1'b1;
    end else if (err_clr_i) begin
      err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      idx   <= '0;
      lvl_q <= MAX_LVL;
      rng_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          idx   <= '0;
          rng_q <= !in_range;
          if (!in_range || err_q) begin
            st <= S_FIN;
          end else begin
            lvl_q <= level_i;
            st    <= S_LVL;
          end
        end
        S_LVL: if (hs) begin
          if (last_lvl) begin
            idx <= '0;
            st  <= (err_q || wr_err_i) ? S_FIN : S_CMT;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_CMT: if (hs) begin
          if (last_cmt) st <= S_FIN;
          else          idx <= idx + 1'b1;
        end
        default: begin
          st    <= S_IDLE;
          rng_q <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/gamma_seq_chk.sv
module gamma_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_ready_i,
  input logic       wr_valid_o,
  input logic [7:0] wr_data_o,
  input logic       wr_first_o,
  input logic       wr_last_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o
);

  a_r5_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_data_o) &&
                                     $stable(wr_first_o) && $stable(wr_last_o)));

  a_r2_lead_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_first_o) |-> (wr_data_o == 8'hFA));

  a_r9_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> busy_o);

  a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (busy_o && !wr_valid_o));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_err_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

endmodule

bind gamma_seq gamma_seq_chk u_chk (.*);

// File: tb/gamma_seq_bench.sv
module gamma_seq_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       start_i = 0;
  logic [3:0] level_i = 0;
  logic       wr_ready_i = 1;
  logic       wr_err_i = 0;
  logic       err_clr_i = 0;
  logic       wr_valid_o, wr_first_o, wr_last_o, busy_o, done_o, err_o;
  logic [7:0] wr_data_o;
  logic [3:0] cur_level_o;

  int n_chk = 0, n_fail = 0;
  bit stall_mode = 0;
  bit finished = 0;
  logic [9:0] q[$];

  gamma_seq u_gamma_seq (.*);

  always #5 clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin : ready_drv
    int rc = 0;
    forever begin
      @(posedge clk); #1;
      rc++;
      wr_ready_i = stall_mode ? ((rc % 3) != 0) : 1'b1;
    end
  end

  // monitor / scoreboard: R2 R3 R4 R5
  bit         prev_stall = 0;
  logic [9:0] prev_item;
  always @(negedge clk) if (rst_n) begin
    if (prev_stall)
      chk(wr_valid_o && {wr_first_o, wr_last_o, wr_data_o} == prev_item, "R5 hold",
          {wr_valid_o, wr_first_o, wr_last_o, wr_data_o}, {1'b1, prev_item});
    if (wr_valid_o && wr_ready_i) begin
      prev_stall = 0;
      if (q.size() == 0) chk(0, "R3 unexpected byte", wr_data_o, 0);
      else begin
        logic [9:0] e;
        e = q.pop_front();
        chk({wr_first_o, wr_last_o, wr_data_o} == e, "R2/R3/R4 byte",
            {wr_first_o, wr_last_o, wr_data_o}, e);
      end
    end else if (wr_valid_o) begin
      prev_stall = 1;
      prev_item = {wr_first_o, wr_last_o, wr_data_o};
    end else prev_stall = 0;
  end

  task automatic push_level(int l);
    for (int i = 0; i < 23; i++) begin
      logic [7:0] b;
      b = (i == 0) ? 8'hFA : (i == 1) ? 8'h00 : 8'((l*11 + (i-2)*37 + 24) % 256);
      q.push_back({i == 0, i == 22, b});
    end
  endtask

  task automatic push_commit();
    q.push_back({2'b10, 8'hFA});
    q.push_back({2'b01, 8'h01});
  endtask

  task automatic run(int lvl, bit pkt, bit cmt, bit exp_err, int inj, int restart, string req);
    int n = 0;
    if (pkt) push_level(lvl);
    if (cmt) push_commit();
    @(negedge clk); start_i = 1; level_i = 4'(lvl);
    @(negedge clk); start_i = 0;
    chk(busy_o == 1, "R9 busy after accept", busy_o, 1);
    while (!done_o && n < 600) begin
      n++;
      wr_err_i = (n == inj);
      start_i  = (n == restart);
      if (n == restart) level_i = 4'd2;
      @(negedge clk);
    end
    wr_err_i = 0; start_i = 0;
    chk(done_o == 1, {req, " done seen"}, done_o, 1);
    chk(err_o == exp_err, {req, " error flag"}, err_o, exp_err);
    chk(q.size() == 0, {req, " all bytes sent"}, q.size(), 0);
    q.delete();
    @(negedge clk);
    chk(done_o == 0 && busy_o == 0, "R6 done single/idle", {done_o, busy_o}, 0);
  endtask

  initial begin : watchdog
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(busy_o == 0 && wr_valid_o == 0 && done_o == 0, "R1 idle", {busy_o, wr_valid_o, done_o}, 0);
    chk(cur_level_o == 10, "R1 level", cur_level_o, 10);
    // R2 R3 R6 with ready held high
    run(3, 1, 1, 0, -1, -1, "R6");
    chk(cur_level_o == 3, "R6 level", cur_level_o, 3);
    // R5 stalls
    stall_mode = 1;
    run(0, 1, 1, 0, -1, -1, "R5");
    run(10, 1, 1, 0, -1, -1, "R2");
    chk(cur_level_o == 10, "R6 level", cur_level_o, 10);
    // R7 out of range
    run(11, 0, 0, 1, -1, -1, "R7");
    run(15, 0, 0, 1, -1, -1, "R7");
    chk(cur_level_o == 10, "R7 level kept", cur_level_o, 10);
    // R9 restart ignored
    run(5, 1, 1, 0, -1, 4, "R9");
    chk(cur_level_o == 5, "R9 level", cur_level_o, 5);
    // R8 writer error
    run(7, 1, 0, 1, 5, -1, "R8");
    chk(cur_level_o == 7, "R8 level", cur_level_o, 7);
    run(1, 0, 0, 1, -1, -1, "R8 sticky");
    chk(cur_level_o == 7, "R8 sticky level", cur_level_o, 7);
    @(negedge clk); err_clr_i = 1;
    @(negedge clk); err_clr_i = 0;
    stall_mode = 0;
    run(1, 1, 1, 0, -1, -1, "R8 cleared");
    chk(cur_level_o == 1, "R8 cleared level", cur_level_o, 1);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule